// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Front End

This block is the bus-facing half of a small serial EEPROM. It watches the two-wire clock and data lines, recognises start and stop conditions, and takes in a write transaction one byte at a time. A write transaction has this order: a device address byte with the direction bit low, a word address byte, one or more data bytes, and then a stop. The block acknowledges each accepted byte by pulling the data line low during the ninth clock. It passes the decoded word address and each data byte to a downstream page engine as one-cycle strobes. When a stop closes a transaction that carried data, it issues a commit strobe.

The page engine raises `busy_i` while its internal write cycle runs. During that time the front end drops any write transfer in progress, makes no strobes, and leaves the device address unacknowledged. A bus master can therefore poll by repeating start plus device address until it gets an acknowledge. After busy clears, a matching address is acknowledged again for either direction bit. A read request is acknowledged and then handed off, and the block returns to idle.

Top module: `twi_eeprom_wr_frontend`

## Requirements
- R1: Conditions are judged only while SCL is high: SDA falling is a start and SDA rising is a stop. After reset, and in the cycles after any stop, `sda_oe` is 0 and no strobe is active.
- R2: A device address byte, sent MSB first, whose bits [7:1] equal `dev_id_i` and whose bit 0 is 0 is acknowledged, provided `busy_i` is low. The acknowledge is `sda_oe`=1 through the ninth SCL high phase.
- R3: A device address whose bits [7:1] differ from `dev_id_i` is not acknowledged. Every later byte before the next start is then also unacknowledged and produces no strobe.
- R4: The byte after an accepted write address is acknowledged, appears on `word_addr_o`, and is marked by a one-cycle `addr_load_o` pulse.
- R5: Each byte after the word address is acknowledged, appears on `data_o` MSB first, and is marked by its own one-cycle `data_strobe_o` pulse.
- R6: A stop that follows at least one complete data byte gives exactly one `commit_o` pulse.
- R7: A stop that comes before any complete data byte, including a stop partway through a byte, gives no `commit_o`.
- R8: While `busy_i` is high, the device address is not acknowledged and no `addr_load_o`, `data_strobe_o` or `commit_o` pulse is made.
- R9: Once `busy_i` has dropped, a matching device address is acknowledged for either value of bit 0.
- R10: A start that arrives partway through a byte discards that byte without a strobe and begins a fresh transaction at the device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | Page engine write cycle in progress |
| dev_id_i | input | 7 | Configured device address |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| word_addr_o | output | 8 | Last received word address |
| addr_load_o | output | 1 | One-cycle pulse: word address valid |
| data_o | output | 8 | Last received data byte |
| data_strobe_o | output | 1 | One-cycle pulse: data byte valid |
| commit_o | output | 1 | One-cycle pulse: start the write cycle |

## Verification
A wrong phase or bit count shows up at the ports within one byte time. Either the acknowledge is missing or misplaced on the ninth clock, or a strobe carries a byte shifted by one bit. A data-received flag that leaks across transactions shows up at the next stop as a commit that should not be there or one that is missing. A busy gate that fails shows as an acknowledge during the polling address, about four system cycles after the eighth SCL fall. Each port effect appears within about four system cycles of the bus edge that causes it, because of the two synchroniser flops, the edge register and the output register.

// File: rtl/twi_wr_pkg.sv
package twi_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DEV  = 2'd1,
    PH_WORD = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

endpackage

// File: rtl/twi_line_sync.sv
// Brings both bus lines into the clock domain and reports bus events.
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  localparam int LINES = 2;
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign now[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= now;
  end

  assign scl_rise = now[IDX_SCL] & ~prev[IDX_SCL];
  assign scl_fall = ~now[IDX_SCL] & prev[IDX_SCL];
  assign ev_start = now[IDX_SCL] & prev[IDX_SCL] & prev[IDX_SDA] & ~now[IDX_SDA];
  assign ev_stop  = now[IDX_SCL] & prev[IDX_SCL] & ~prev[IDX_SDA] & now[IDX_SDA];
endmodule

// File: rtl/twi_bit_shifter.sv
// MSB-first deserialiser with a bit counter that saturates at W.
module twi_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] value,
  output logic         full
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      value <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en && !full) begin
      value <= {value[W-2:0], bit_i};
      cnt   <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/twi_wr_ctrl.sv
// Transaction sequencer: phase tracking, acknowledge decision and strobes.
module twi_wr_ctrl
  import twi_wr_pkg::*;
#(
  parameter int W = 8,
  localparam int ID_W = W - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            busy_i,
  input  logic [ID_W-1:0] dev_id_i,
  input  logic [W-1:0]    byte_val,
  input  logic            byte_full,
  output logic            shift_en,
  output logic            shift_clr,
  output logic            byte_done,
  output phase_e          phase,
  output logic            ack_q,
  output logic [W-1:0]    word_addr,
  output logic            addr_load,
  output logic [W-1:0]    data_byte,
  output logic            data_stb,
  output logic            commit
);
  logic got_data;

  function automatic logic id_match(input logic [W-1:0] b, input logic [ID_W-1:0] id);
    return b[W-1:1] == id;
  endfunction

  function automatic logic wants_read(input logic [W-1:0] b);
    return b[0];
  endfunction

  logic in_xfer;
  assign in_xfer   = (phase == PH_WORD) || (phase == PH_DATA);
  assign shift_en  = scl_rise && (phase != PH_IDLE) && !ack_q;
  assign byte_done = scl_fall && byte_full && !ack_q && (phase != PH_IDLE);
  assign shift_clr = ev_start || ev_stop || byte_done || (scl_fall && ack_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      ack_q     <= 1'b0;
      got_data  <= 1'b0;
      word_addr <= '0;
      data_byte <= '0;
      addr_load <= 1'b0;
      data_stb  <= 1'b0;
      commit    <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      data_stb  <= 1'b0;
      commit    <= 1'b0;
      if (ev_start) begin
        phase    <= PH_DEV;
        ack_q    <= 1'b0;
        got_data <= 1'b0;
      end else if (ev_stop) begin
        phase    <= PH_IDLE;
        ack_q    <= 1'b0;
        commit   <= got_data && !busy_i;
        got_data <= 1'b0;
      end else if (busy_i && in_xfer) begin
        phase    <= PH_IDLE;
        got_data <= 1'b0;
      end else if (byte_done) begin
        unique case (phase)
          PH_DEV: begin
            if (id_match(byte_val, dev_id_i) && !busy_i) begin
              ack_q <= 1'b1;
              phase <= wants_read(byte_val) ? PH_IDLE : PH_WORD;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_WORD: begin
            ack_q     <= 1'b1;
            word_addr <= byte_val;
            addr_load <= 1'b1;
            phase     <= PH_DATA;
          end
          PH_DATA: begin
            ack_q     <= 1'b1;
            data_byte <= byte_val;
            data_stb  <= 1'b1;
            got_data  <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end else if (scl_fall && ack_q) begin
        ack_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_wr_frontend.sv
module twi_eeprom_wr_frontend
  import twi_wr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic [ID_W-1:0]   dev_id_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] word_addr_o,
  output logic              addr_load_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_strobe_o,
  output logic              commit_o
);
  logic scl_rise, scl_fall, ev_start, ev_stop;
  logic shift_en, shift_clr, byte_done, byte_full;
  logic [BYTE_W-1:0] byte_val;
  phase_e phase;
  logic in_dev_phase;
  logic sda_now;

  // sda sampled through the same synchroniser depth for the shifter
  logic [SYNC_STAGES-1:0] sda_chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_chain <= '1;
    else        sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
  end
  assign sda_now = sda_chain[SYNC_STAGES-1];

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  twi_bit_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr), .shift_en(shift_en),
    .bit_i(sda_now), .value(byte_val), .full(byte_full)
  );

  twi_wr_ctrl #(.W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .busy_i(busy_i), .dev_id_i(dev_id_i),
    .byte_val(byte_val), .byte_full(byte_full),
    .shift_en(shift_en), .shift_clr(shift_clr), .byte_done(byte_done),
    .phase(phase), .ack_q(sda_oe),
    .word_addr(word_addr_o), .addr_load(addr_load_o),
    .data_byte(data_o), .data_stb(data_strobe_o),
    .commit(commit_o)
  );

  assign in_dev_phase = (phase == PH_DEV);
endmodule

// File: rtl/twi_wr_checker.sv
module twi_wr_checker (
  input logic clk,
  input logic rst_n,
  input logic busy_i,
  input logic sda_oe,
  input logic addr_load_o,
  input logic data_strobe_o,
  input logic commit_o,
  input logic ev_start,
  input logic ev_stop,
  input logic byte_done,
  input logic in_dev_phase
);
  logic seen_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_data <= 1'b0;
    else if (ev_start)      seen_data <= 1'b0;
    else if (data_strobe_o) seen_data <= 1'b1;
    else if (commit_o)      seen_data <= 1'b0;
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe); // R1
  AST_LOAD_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load_o |-> sda_oe); // R4
  AST_DATA_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe_o |-> sda_oe); // R5
  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> seen_data); // R6
  AST_BUSY_DEV_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_dev_phase && busy_i) |=> !sda_oe); // R8
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> !(addr_load_o || data_strobe_o || commit_o)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load_o, data_strobe_o, commit_o})); // R5
endmodule

bind twi_eeprom_wr_frontend twi_wr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_oe(sda_oe),
  .addr_load_o(addr_load_o), .data_strobe_o(data_strobe_o), .commit_o(commit_o),
  .ev_start(ev_start), .ev_stop(ev_stop), .byte_done(byte_done),
  .in_dev_phase(in_dev_phase)
);

// File: tb/twi_eeprom_wr_frontend_test.sv
`timescale 1ns/1ps
module twi_eeprom_wr_frontend_test;
  localparam int HALF = 8;
  localparam int BUSY_CYC = 600;
  localparam logic [6:0] MY_ID = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic busy_i = 1'b0;
  logic sda_oe, addr_load_o, data_strobe_o, commit_o;
  logic [7:0] word_addr_o, data_o;
  logic sda_line;

  int checks = 0, failures = 0;
  int n_addr = 0, n_data = 0, n_commit = 0, busy_cnt = 0;
  logic [7:0] last_addr;
  logic [7:0] data_log [0:31];
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom_wr_frontend uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .busy_i(busy_i), .dev_id_i(MY_ID), .sda_oe(sda_oe),
    .word_addr_o(word_addr_o), .addr_load_o(addr_load_o),
    .data_o(data_o), .data_strobe_o(data_strobe_o), .commit_o(commit_o)
  );

  // strobe monitor and page engine busy model
  always @(negedge clk) begin
    if (addr_load_o) begin n_addr++; last_addr = word_addr_o; end
    if (data_strobe_o) begin
      if (n_data < 32) data_log[n_data] = data_o;
      n_data++;
    end
    if (commit_o) begin n_commit++; busy_cnt = BUSY_CYC; end
    else if (busy_cnt > 0) busy_cnt--;
    busy_i = (busy_cnt > 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1;   wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl = 1'b0;   wt(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl = 1'b1;   wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(HALF);
    scl = 1'b1; wt(HALF);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(HALF);
    scl = 1'b1; wt(HALF / 2);
    acked = ~sda_line;
    wt(HALF / 2);
    scl = 1'b0; wt(HALF);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    logic ack;
    int base;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    chk(n_addr + n_data + n_commit == 0, "R1 no strobes after reset", n_addr + n_data + n_commit, 0);

    // sweep every device id, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      if (a == int'(MY_ID)) begin
        chk(ack == 1'b1, "R2 matching id acked", ack, 1);
      end else begin
        chk(ack == 1'b0, "R3 foreign id nacked", ack, 0);
        send_byte(8'h5A, ack);
        chk(ack == 1'b0, "R3 byte after foreign id nacked", ack, 0);
      end
      bus_stop();
      chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    end
    chk(n_addr == 0 && n_data == 0, "R3 no strobes in sweep", n_addr + n_data, 0);
    chk(n_commit == 0, "R7 stop without data no commit", n_commit, 0);

    // full page write of ten bytes
    bus_start();
    send_byte({MY_ID, 1'b0}, ack);
    chk(ack, "R2 write address acked", ack, 1);
    send_byte(8'h3C, ack);
    chk(ack, "R4 word address acked", ack, 1);
    chk(n_addr == 1 && last_addr == 8'h3C, "R4 word address value", last_addr, 8'h3C);
    for (int i = 0; i < 10; i++) begin
      send_byte(pat(i), ack);
      chk(ack, "R5 data byte acked", ack, 1);
      chk(n_data == i + 1 && data_log[i] == pat(i), "R5 data byte value", data_log[i], pat(i));
    end
    chk(n_commit == 0, "R6 no commit before stop", n_commit, 0);
    bus_stop();
    chk(n_commit == 1, "R6 one commit on stop", n_commit, 1);
    chk(busy_i == 1'b1, "R8 busy model running", busy_i, 1);

    // acknowledge polling while busy
    bus_start();
    send_byte({MY_ID, 1'b0}, ack);
    chk(ack == 1'b0, "R8 address nacked while busy", ack, 0);
    send_byte(8'h11, ack);
    chk(ack == 1'b0, "R8 word byte nacked while busy", ack, 0);
    bus_stop();
    chk(n_addr == 1 && n_data == 10 && n_commit == 1, "R8 no strobes while busy", n_addr + n_data + n_commit, 12);

    while (busy_i) wt(1);
    bus_start();
    send_byte({MY_ID, 1'b1}, ack);
    chk(ack == 1'b1, "R9 read direction acked after busy", ack, 1);
    bus_stop();
    bus_start();
    send_byte({MY_ID, 1'b0}, ack);
    chk(ack == 1'b1, "R9 write direction acked after busy", ack, 1);
    bus_stop();
    chk(n_commit == 1, "R7 address-only stop no commit", n_commit, 1);

    // repeated start partway through a data byte
    base = n_data;
    bus_start();
    send_byte({MY_ID, 1'b0}, ack);
    send_byte(8'h07, ack);
    send_byte(8'h11, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte({MY_ID, 1'b0}, ack);
    chk(ack, "R10 address after repeated start acked", ack, 1);
    send_byte(8'h08, ack);
    chk(last_addr == 8'h08, "R10 new word address", last_addr, 8'h08);
    send_byte(8'h22, ack);
    chk(n_data == base + 2, "R10 partial byte dropped", n_data - base, 2);
    chk(data_log[base] == 8'h11 && data_log[base + 1] == 8'h22, "R10 data order", data_log[base + 1], 8'h22);
    bus_stop();
    chk(n_commit == 2, "R6 commit after repeated start write", n_commit, 2);

    // stop partway through the first data byte
    while (busy_i) wt(1);
    base = n_data;
    bus_start();
    send_byte({MY_ID, 1'b0}, ack);
    send_byte(8'h09, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop();
    wt(10);
    chk(n_commit == 2, "R7 stop mid byte no commit", n_commit, 2);
    chk(n_data == base, "R7 stop mid byte no data", n_data - base, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule